// File: doc/BRIEF.md
# Frame Buffer Streaming Read Master

This block fetches the image held in an external frame buffer and keeps a local pixel FIFO topped up, with no processor work per word. Software programs a start byte address and a frame size in 32-bit words through a four-entry register port, then sets an enable bit. From then on the master issues single-word reads at ascending addresses. It returns to the start address after the last word of each frame and runs until the enable bit is cleared.

Reads are throttled by FIFO space. The master counts words already held in the FIFO together with reads accepted by the bus but not yet answered, and raises a new request only while that total leaves room for one more word. A display-side consumer pops words from the FIFO's head. A status register reports whether the master is busy and holds a sticky flag for returned data that found the FIFO full.

Top module: `fb_stream_master`

## Requirements
- R1: After reset, m_read and px_valid are low, and all four registers read back as zero.
- R2: Register select 0 is control (bit 0 = enable), 1 is the start byte address, 2 is the frame length in words, and 3 is status. A write strobe stores cfg_wdata into the selected register. cfg_rdata shows the selected register one cycle after a read strobe.
- R3: Accepted reads use the addresses base, base+4, ..., base+4*(len-1), then base again, without end. A length of 0 behaves as a length of 1.
- R4: A read counts as accepted only in a cycle where m_read is high and m_waitreq is low. While m_waitreq is high, m_read and m_addr hold their values.
- R5: Words in the FIFO plus reads accepted but not yet returned never exceed DEPTH. With the consumer stalled, the FIFO fills to DEPTH and m_read stays low.
- R6: Each m_rdvalid word enters the FIFO. px_data shows the words in return order while px_valid is high, and px_pop removes the head word.
- R7: After enable is cleared, the master makes no new request once any pending request has been accepted. Setting enable again restarts at the current start address with the word count at zero.
- R8: Status bit 0 is high while enabled, while a request is pending, or while reads are in flight. Status bit 1 is a sticky flag set when m_rdvalid arrives with the FIFO full; that word is dropped. A status write with bit 1 set clears the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_sel | input | 2 | Register select |
| cfg_wr | input | 1 | Register write strobe |
| cfg_rd | input | 1 | Register read strobe |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data, valid one cycle after cfg_rd |
| m_addr | output | ADDR_W | Read byte address |
| m_read | output | 1 | Read request |
| m_waitreq | input | 1 | Bus stall; the request is not accepted while high |
| m_rdvalid | input | 1 | Read data valid |
| m_rdata | input | 32 | Read data |
| px_pop | input | 1 | Consumer removes the head word |
| px_valid | output | 1 | FIFO holds at least one word |
| px_data | output | 32 | Head word of the FIFO |

## Verification
All stimulus is driven on the falling edge, and the bench samples at that same point, half a cycle away from the active edge. Register read data is compared one falling edge after the strobe is applied. A word driven with m_rdvalid is expected at px_data from the next falling edge onward. An acceptance is predicted from the m_read level and the m_waitreq value chosen for the coming edge, and the address is compared at that moment. The hold rule is checked one cycle later, and the quiet-after-disable rule is checked only after enough cycles for a pending request to be accepted.

// File: rtl/fbsm_pkg.sv
package fbsm_pkg;
   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_BASE = 2'd1,
      SEL_LEN  = 2'd2,
      SEL_STAT = 2'd3
   } fbsm_sel_e;

   localparam int unsigned CTRL_EN_BIT  = 0;
   localparam int unsigned STAT_BSY_BIT = 0;
   localparam int unsigned STAT_OVF_BIT = 1;
   localparam int unsigned WORD_BYTES   = 4;
endpackage

// File: rtl/fbsm_regs.sv
module fbsm_regs
   import fbsm_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_sel,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [31:0]       cfg_wdata,
   input  logic              busy,
   input  logic              ovf_evt,
   output logic              en,
   output logic [ADDR_W-1:0] base,
   output logic [LEN_W-1:0]  len,
   output logic              ovf,
   output logic [31:0]       cfg_rdata
);
   logic [31:0] base_rd, len_rd;
   logic        stat_wr;

   if (ADDR_W < 32) begin : g_base_pad
      assign base_rd = {{(32-ADDR_W){1'b0}}, base};
   end else begin : g_base_full
      assign base_rd = base;
   end

   if (LEN_W < 32) begin : g_len_pad
      assign len_rd = {{(32-LEN_W){1'b0}}, len};
   end else begin : g_len_full
      assign len_rd = len;
   end

   assign stat_wr = cfg_wr && (fbsm_sel_e'(cfg_sel) == SEL_STAT);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en   <= 1'b0;
         base <= '0;
         len  <= '0;
      end else if (cfg_wr) begin
         case (fbsm_sel_e'(cfg_sel))
            SEL_CTRL: en   <= cfg_wdata[CTRL_EN_BIT];
            SEL_BASE: base <= cfg_wdata[ADDR_W-1:0];
            SEL_LEN:  len  <= cfg_wdata[LEN_W-1:0];
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ovf <= 1'b0;
      else if (ovf_evt)
         ovf <= 1'b1;
      else if (stat_wr && cfg_wdata[STAT_OVF_BIT])
         ovf <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         cfg_rdata <= '0;
      else if (cfg_rd) begin
         case (fbsm_sel_e'(cfg_sel))
            SEL_CTRL: cfg_rdata <= {31'd0, en};
            SEL_BASE: cfg_rdata <= base_rd;
            SEL_LEN:  cfg_rdata <= len_rd;
            default:  cfg_rdata <= {30'd0, ovf, busy};
         endcase
      end
   end
endmodule

// File: rtl/fbsm_seq.sv
module fbsm_seq
   import fbsm_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 24,
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned LVL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic [ADDR_W-1:0] base,
   input  logic [LEN_W-1:0]  len,
   input  logic              waitreq,
   input  logic              rdvalid,
   input  logic [LVL_W-1:0]  level,
   output logic              m_read,
   output logic [ADDR_W-1:0] m_addr,
   output logic [LVL_W-1:0]  inflight
);
   localparam logic [ADDR_W-1:0] STEP  = ADDR_W'(WORD_BYTES);
   localparam logic [LVL_W:0]    LIMIT = (LVL_W+1)'(DEPTH);

   logic              req_q;
   logic [ADDR_W-1:0] ptr;
   logic [LEN_W-1:0]  cnt;
   logic              accept, ret, last, room;
   logic [LVL_W:0]    sum;

   assign accept = req_q && !waitreq;
   assign ret    = rdvalid && (inflight != '0);
   assign last   = ({1'b0, cnt} + 1'b1) >= {1'b0, len};
   assign sum    = {1'b0, level} + {1'b0, inflight} + (LVL_W+1)'(accept);
   assign room   = sum < LIMIT;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_q    <= 1'b0;
         inflight <= '0;
      end else begin
         req_q    <= (req_q && waitreq) || (en && room);
         inflight <= inflight + LVL_W'(accept) - LVL_W'(ret);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr <= '0;
         cnt <= '0;
      end else if (!en && !req_q) begin
         ptr <= base;
         cnt <= '0;
      end else if (accept) begin
         if (last) begin
            ptr <= base;
            cnt <= '0;
         end else begin
            ptr <= ptr + STEP;
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign m_read = req_q;
   assign m_addr = ptr;
endmodule

// File: rtl/fbsm_fifo.sv
module fbsm_fifo #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned LVL_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push,
   input  logic [DATA_W-1:0] wdata,
   input  logic              pop,
   output logic [DATA_W-1:0] rdata,
   output logic [LVL_W-1:0]  level,
   output logic              full,
   output logic              empty
);
   localparam int unsigned      PTR_W    = $clog2(DEPTH);
   localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);

   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wp, rp;
   logic              do_push, do_pop;

   assign full    = (level == FULL_LVL);
   assign empty   = (level == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign rdata   = mem[rp];

   always_ff @(posedge clk) begin
      if (do_push)
         mem[wp] <= wdata;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wp    <= '0;
         rp    <= '0;
         level <= '0;
      end else begin
         if (do_push) wp <= wp + 1'b1;
         if (do_pop)  rp <= rp + 1'b1;
         level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
      end
   end
endmodule

// File: rtl/fb_stream_master.sv
module fb_stream_master
   import fbsm_pkg::*;
#(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned LEN_W  = 24,
   parameter int unsigned DEPTH  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        cfg_sel,
   input  logic              cfg_wr,
   input  logic              cfg_rd,
   input  logic [31:0]       cfg_wdata,
   output logic [31:0]       cfg_rdata,
   output logic [ADDR_W-1:0] m_addr,
   output logic              m_read,
   input  logic              m_waitreq,
   input  logic              m_rdvalid,
   input  logic [31:0]       m_rdata,
   input  logic              px_pop,
   output logic              px_valid,
   output logic [31:0]       px_data
);
   localparam int unsigned LVL_W = $clog2(DEPTH + 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (ADDR_W < 3 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie in 3..32");
   end
   if (LEN_W < 1 || LEN_W > 32) begin : g_bad_len
      $error("LEN_W must lie in 1..32");
   end

   logic              en, ovf, busy, full, empty, ovf_evt;
   logic [ADDR_W-1:0] base;
   logic [LEN_W-1:0]  len;
   logic [LVL_W-1:0]  level, inflight;

   assign busy     = en || m_read || (inflight != '0);
   assign ovf_evt  = m_rdvalid && full;
   assign px_valid = !empty;

   fbsm_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
      .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata), .busy(busy),
      .ovf_evt(ovf_evt), .en(en), .base(base), .len(len), .ovf(ovf),
      .cfg_rdata(cfg_rdata)
   );

   fbsm_seq #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .en(en), .base(base), .len(len),
      .waitreq(m_waitreq), .rdvalid(m_rdvalid), .level(level),
      .m_read(m_read), .m_addr(m_addr), .inflight(inflight)
   );

   fbsm_fifo #(.DATA_W(32), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(m_rdvalid), .wdata(m_rdata),
      .pop(px_pop), .rdata(px_data), .level(level), .full(full),
      .empty(empty)
   );
endmodule

// File: rtl/fbsm_chk.sv
module fbsm_chk #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DEPTH  = 8,
   parameter int unsigned LVL_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              m_read,
   input logic              m_waitreq,
   input logic [ADDR_W-1:0] m_addr,
   input logic              en,
   input logic [ADDR_W-1:0] base,
   input logic [LVL_W-1:0]  level,
   input logic [LVL_W-1:0]  inflight
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);
   localparam logic [LVL_W:0]    CAP  = (LVL_W+1)'(DEPTH);

   // R4: a stalled request keeps its strobe and address
   a_r4_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
      (m_read && m_waitreq) |=> (m_read && m_addr == $past(m_addr)));

   // R3: an accepted read moves to the next word or back to the start
   a_r3_next_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (m_read && !m_waitreq && en) |=>
         (m_addr == $past(m_addr) + STEP) || (m_addr == $past(base)));

   // R5: a request is only up while the FIFO has reserved space
   a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
      m_read |-> (({1'b0, level} + {1'b0, inflight}) < CAP));

   // R7: a disabled master with nothing pending stays quiet
   a_r7_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !m_read) |=> !m_read);
endmodule

bind fb_stream_master fbsm_chk #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .m_read(m_read), .m_waitreq(m_waitreq),
   .m_addr(m_addr), .en(en), .base(base), .level(level), .inflight(inflight)
);

// File: tb/sim_fb_stream_master.sv
`timescale 1ns/1ps
module sim_fb_stream_master;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  cfg_sel = '0;
   logic        cfg_wr = 1'b0, cfg_rd = 1'b0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [31:0] m_addr;
   logic        m_read;
   logic        m_waitreq = 1'b0, m_rdvalid = 1'b0;
   logic [31:0] m_rdata = '0;
   logic        px_pop = 1'b0;
   logic        px_valid;
   logic [31:0] px_data;

   always #4 clk = ~clk;

   fb_stream_master u0 (
      .clk(clk), .rst_n(rst_n), .cfg_sel(cfg_sel), .cfg_wr(cfg_wr),
      .cfg_rd(cfg_rd), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
      .m_addr(m_addr), .m_read(m_read), .m_waitreq(m_waitreq),
      .m_rdvalid(m_rdvalid), .m_rdata(m_rdata), .px_pop(px_pop),
      .px_valid(px_valid), .px_data(px_data)
   );

   int n_chk = 0, n_fail = 0;
   int wait_pct = 0, ret_pct = 100, pop_pct = 0;
   bit idle_chk = 0, inject = 0, held_prev = 0;
   logic [31:0] held_addr = '0;
   logic [31:0] exp_base = '0;
   int          exp_len = 1, exp_cnt = 0;
   logic [31:0] memq[$];
   logic [31:0] pixq[$];

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] word_of(logic [31:0] a);
      return a ^ 32'hC3A5_0000 ^ {a[7:0], 24'h0};
   endfunction

   task automatic tick();
      logic [31:0] hd;
      if (held_prev)
         check(m_read && m_addr == held_addr, "R4 hold", m_addr, held_addr);
      if (idle_chk)
         check(!m_read, "R7 quiet", {31'd0, m_read}, 32'd0);
      // consumer side, head before this edge
      px_pop = 1'b0;
      if (px_valid && ($urandom % 100) < pop_pct) begin
         hd = (pixq.size() > 0) ? pixq.pop_front() : 32'hxxxx_xxxx;
         check(px_data === hd, "R6 order", px_data, hd);
         px_pop = 1'b1;
      end
      // memory returns
      m_rdvalid = 1'b0;
      if (inject) begin
         m_rdvalid = 1'b1;
         m_rdata   = 32'hDEAD_BEEF;
      end else if (memq.size() > 0 && ($urandom % 100) < ret_pct) begin
         m_rdvalid = 1'b1;
         m_rdata   = word_of(memq.pop_front());
         pixq.push_back(m_rdata);
      end
      // request acceptance
      m_waitreq = (($urandom % 100) < wait_pct);
      if (m_read && !m_waitreq) begin
         check(m_addr == exp_base + 32'(4 * exp_cnt), "R3 addr", m_addr,
               exp_base + 32'(4 * exp_cnt));
         memq.push_back(m_addr);
         exp_cnt = (exp_cnt + 1 >= exp_len) ? 0 : exp_cnt + 1;
      end
      held_prev = m_read && m_waitreq;
      held_addr = m_addr;
      if (pixq.size() + memq.size() > DEPTH)
         check(0, "R5 bound", 32'(pixq.size() + memq.size()), DEPTH);
      @(negedge clk);
   endtask

   task automatic cfg_write(logic [1:0] s, logic [31:0] d);
      cfg_sel = s; cfg_wdata = d; cfg_wr = 1'b1;
      tick();
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_read(logic [1:0] s, output logic [31:0] d);
      cfg_sel = s; cfg_rd = 1'b1;
      tick();
      cfg_rd = 1'b0;
      d = cfg_rdata;
   endtask

   task automatic start(logic [31:0] b, int l);
      cfg_write(2'd1, b);
      cfg_write(2'd2, 32'(l));
      exp_base = b;
      exp_len  = (l == 0) ? 1 : l;
      exp_cnt  = 0;
      cfg_write(2'd0, 32'd1);
   endtask

   task automatic stop_and_drain();
      int saved;
      saved = wait_pct;
      wait_pct = 0; ret_pct = 100;
      cfg_write(2'd0, 32'd0);
      repeat (6) tick();
      idle_chk = 1;
      repeat (12) tick();
      idle_chk = 0;
      wait_pct = saved;
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      check(0, "watchdog", 32'd0, 32'd1);
      finish_run();
   end

   initial begin
      logic [31:0] rv;
      void'($urandom(32'd20931));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(!m_read, "R1 m_read", {31'd0, m_read}, 0);
      check(!px_valid, "R1 px_valid", {31'd0, px_valid}, 0);
      for (int i = 0; i < 4; i++) begin
         cfg_read(2'(i), rv);
         check(rv == 0, "R1 reg zero", rv, 0);
      end
      // R2 register access
      cfg_write(2'd1, 32'h0000_1000);
      cfg_write(2'd2, 32'd5);
      cfg_read(2'd1, rv); check(rv == 32'h1000, "R2 base", rv, 32'h1000);
      cfg_read(2'd2, rv); check(rv == 5, "R2 len", rv, 5);
      // R3/R4/R6 random streaming
      wait_pct = 30; ret_pct = 60; pop_pct = 50;
      start(32'h0000_1000, 5);
      cfg_read(2'd0, rv); check(rv == 1, "R2 ctrl", rv, 1);
      repeat (400) tick();
      cfg_read(2'd3, rv); check(rv[0] == 1'b1, "R8 busy", rv, 1);
      // R5 stalled consumer
      pop_pct = 0; ret_pct = 100;
      repeat (60) tick();
      check(pixq.size() == DEPTH, "R5 fill", 32'(pixq.size()), DEPTH);
      check(!m_read, "R5 no req", {31'd0, m_read}, 0);
      check(px_valid, "R6 valid", {31'd0, px_valid}, 1);
      // R7 disable
      stop_and_drain();
      cfg_read(2'd3, rv); check(rv == 0, "R8 idle", rv, 0);
      // R8 overflow: spurious word into a full FIFO
      inject = 1; tick(); inject = 0;
      cfg_read(2'd3, rv); check(rv == 2, "R8 ovf set", rv, 2);
      pop_pct = 100;
      while (pixq.size() > 0) tick();
      tick();
      check(!px_valid, "R8 dropped word", {31'd0, px_valid}, 0);
      cfg_write(2'd3, 32'd2);
      cfg_read(2'd3, rv); check(rv == 0, "R8 ovf clear", rv, 0);
      // R7 restart at a new base, length 1
      wait_pct = 25; ret_pct = 50; pop_pct = 60;
      start(32'h0000_2000, 1);
      repeat (120) tick();
      stop_and_drain();
      // R3 length 0 behaves as 1
      start(32'h0000_3000, 0);
      repeat (80) tick();
      stop_and_drain();
      // R7 re-enable restarts with count zero
      start(32'h0000_4000, 7);
      repeat (300) tick();
      stop_and_drain();
      pop_pct = 100;
      while (pixq.size() > 0) tick();
      check(memq.size() == 0, "R6 all returned", 32'(memq.size()), 0);
      finish_run();
   end
endmodule